// File: doc/BRIEF.md
# Bus Data Pattern Set/Clear Detector

The block listens passively to a processor read-data bus and keeps a single status bit, meant to drive an indicator lamp. On every rising clock edge it compares the word on the bus against two full-width patterns. A match with the "on" pattern raises the bit. A match with the "off" pattern lowers it. Every other word leaves the bit where it was. The bus is never acknowledged or stalled, so the block can be attached to any read path without changing its timing.

Both patterns are parameters. The defaults are 0xAAAA5555 (on) and 0xF0F0F0F0 (off). The comparison can be built as one wide equality or as a tree of narrower slice matches, chosen by a slice-width parameter. The status bit is held in a register, so it answers on the same edge that samples the matching word and is visible from that edge onward. A synchronous reset puts the bit in a defined idle state.

Top module: `bus_pattern_latch`

## Requirements
- R1: While the synchronous, active-high reset `rst_i` is high at a rising edge, `ind_o` takes the value RESET_VAL after that edge. The default RESET_VAL is 0.
- R2: When `rd_data_i` equals SET_PAT (default 0xAAAA5555) at a rising edge with reset low, `ind_o` is 1 after that edge.
- R3: When `rd_data_i` equals CLR_PAT (default 0xF0F0F0F0) at a rising edge with reset low, and CLR_PAT differs from SET_PAT, `ind_o` is 0 after that edge.
- R4: When `rd_data_i` matches neither pattern at a rising edge with reset low, `ind_o` keeps its value. This includes words that differ from a pattern in a single bit.
- R5: When SET_PAT and CLR_PAT are configured equal, a matching word sets `ind_o` to 1. Set has priority.
- R6: Take a run where the off pattern is on the bus for two consecutive edges and the on pattern follows at the next edge. `ind_o` is low after the first and after the second of those edges, so the low spans three rising edges (the clearing edge through the setting edge). It is high after the third.
- R7: Reset has priority over a matching word. If SET_PAT is on the bus while reset is high, `ind_o` is still RESET_VAL after that edge.
- R8: The bus is compared on every edge with no dead cycles. If the on and off patterns alternate on consecutive edges, `ind_o` toggles after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock. The bus is sampled on its rising edge. |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_data_i | input | DATA_W (32) | Observed read-data bus |
| ind_o | output | 1 | Registered status bit |

## Verification
The assertions assume that `rd_data_i` and `rst_i` are stable and known at each rising edge. They also assume that the bus may carry any word, so no relation between successive words is required. The stimulus changes inputs only on the falling edge and drives only defined values. It mixes exact pattern words, single-bit near misses of both patterns and unrelated words, with reset pulses placed both on idle words and on the on pattern. A second instance with equal patterns supplies the case where both comparisons hit at once.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_SET  = 2'b01,
      ACT_CLR  = 2'b10
   } bpl_action_t;

endpackage

// File: rtl/bpl_match.sv
module bpl_match #(
   parameter int unsigned         DATA_W  = 32,
   parameter int unsigned         SLICE_W = 8,
   parameter logic [DATA_W-1:0]   PATTERN = '0
) (
   input  logic [DATA_W-1:0] data_i,
   output logic              hit_o
);

   localparam int unsigned N_SLICE = DATA_W / SLICE_W;

   if ((SLICE_W == 0) || (DATA_W % SLICE_W != 0)) begin : g_bad_slice
      $error("bpl_match: SLICE_W must divide DATA_W");
   end

   if (N_SLICE <= 1) begin : g_flat
      assign hit_o = (data_i == PATTERN);
   end else begin : g_sliced
      logic [N_SLICE-1:0] slice_eq;
      for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
         assign slice_eq[s] = (data_i[s*SLICE_W +: SLICE_W] == PATTERN[s*SLICE_W +: SLICE_W]);
      end
      assign hit_o = &slice_eq;
   end

endmodule

// File: rtl/bpl_resolve.sv
module bpl_resolve
   import bpl_pkg::*;
(
   input  logic        set_hit_i,
   input  logic        clr_hit_i,
   output bpl_action_t act_o
);

   always_comb begin
      if (set_hit_i) begin
         act_o = ACT_SET;
      end else if (clr_hit_i) begin
         act_o = ACT_CLR;
      end else begin
         act_o = ACT_HOLD;
      end
   end

endmodule

// File: rtl/bus_pattern_latch.sv
module bus_pattern_latch
   import bpl_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       SLICE_W   = 8,
   parameter logic [DATA_W-1:0] SET_PAT   = 32'hAAAA_5555,
   parameter logic [DATA_W-1:0] CLR_PAT   = 32'hF0F0_F0F0,
   parameter logic              RESET_VAL = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              ind_o
);

   if (DATA_W == 0) begin : g_bad_width
      $error("bus_pattern_latch: DATA_W must be non-zero");
   end

   logic        set_hit;
   logic        clr_hit;
   bpl_action_t act;
   logic        ind_q;

   bpl_match #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .PATTERN(SET_PAT)) u_set_match (
      .data_i (rd_data_i),
      .hit_o  (set_hit)
   );

   bpl_match #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .PATTERN(CLR_PAT)) u_clr_match (
      .data_i (rd_data_i),
      .hit_o  (clr_hit)
   );

   bpl_resolve u_resolve (
      .set_hit_i (set_hit),
      .clr_hit_i (clr_hit),
      .act_o     (act)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ind_q <= RESET_VAL;
      end else begin
         case (act)
            ACT_SET: ind_q <= 1'b1;
            ACT_CLR: ind_q <= 1'b0;
            default: ind_q <= ind_q;
         endcase
      end
   end

   assign ind_o = ind_q;

endmodule

// File: rtl/bpl_checker.sv
module bpl_checker #(
   parameter int unsigned       DATA_W    = 32,
   parameter logic [DATA_W-1:0] SET_PAT   = 32'hAAAA_5555,
   parameter logic [DATA_W-1:0] CLR_PAT   = 32'hF0F0_F0F0,
   parameter logic              RESET_VAL = 1'b0
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              ind_o
);

   AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(rst_i) === 1'b1) |-> (ind_o == RESET_VAL)); // R1

   AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_data_i == SET_PAT) |=> ind_o); // R2

   AST_CLR_LOWERS: assert property (@(posedge clk_i) disable iff (rst_i)
      ((rd_data_i == CLR_PAT) && (rd_data_i != SET_PAT)) |=> !ind_o); // R3

   AST_OTHER_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      ((rd_data_i != SET_PAT) && (rd_data_i != CLR_PAT)) |=> $stable(ind_o)); // R4

endmodule

bind bus_pattern_latch bpl_checker #(
   .DATA_W    (DATA_W),
   .SET_PAT   (SET_PAT),
   .CLR_PAT   (CLR_PAT),
   .RESET_VAL (RESET_VAL)
) u_bpl_checker (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .rd_data_i (rd_data_i),
   .ind_o     (ind_o)
);

// File: tb/bus_pattern_latch_test.sv
`timescale 1ns/1ps
module bus_pattern_latch_test;

   localparam logic [31:0] SETW = 32'hAAAA_5555;
   localparam logic [31:0] CLRW = 32'hF0F0_F0F0;
   localparam logic [31:0] EQW  = 32'h1234_5678;

   typedef struct {
      logic  exp_a;
      logic  exp_b;
      string tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] bus = '0;
   logic        ind_a;
   logic        ind_b;

   item_t       sb_q[$];
   int          n_cmp  = 0;
   int          n_bad  = 0;
   logic        mdl_a  = 1'b0;
   logic        mdl_b  = 1'b0;
   bit          done   = 1'b0;

   always #2.5 clk = ~clk;

   bus_pattern_latch uut (
      .clk_i(clk), .rst_i(rst), .rd_data_i(bus), .ind_o(ind_a)
   );

   bus_pattern_latch #(.SLICE_W(32), .SET_PAT(EQW), .CLR_PAT(EQW)) uut_eq (
      .clk_i(clk), .rst_i(rst), .rd_data_i(bus), .ind_o(ind_b)
   );

   task automatic drive(input logic r, input logic [31:0] w, input string tag);
      item_t it;
      @(negedge clk);
      rst = r;
      bus = w;
      if (r) begin
         mdl_a = 1'b0;
         mdl_b = 1'b0;
      end else begin
         if (w == SETW) mdl_a = 1'b1;
         else if (w == CLRW) mdl_a = 1'b0;
         if (w == EQW) mdl_b = 1'b1;
      end
      it.exp_a = mdl_a;
      it.exp_b = mdl_b;
      it.tag   = tag;
      sb_q.push_back(it);
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_cmp++;
            if (ind_a !== it.exp_a) begin
               n_bad++;
               $display("FAIL %s uut: got %b expected %b", it.tag, ind_a, it.exp_a);
            end
            n_cmp++;
            if (ind_b !== it.exp_b) begin
               n_bad++;
               $display("FAIL %s uut_eq: got %b expected %b", it.tag, ind_b, it.exp_b);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      drive(1'b1, 32'h0, "R1 reset");
      drive(1'b1, 32'h0, "R1 reset");
      drive(1'b0, 32'h0000_0000, "R4 idle after reset");
      drive(1'b0, SETW, "R2 set");
      drive(1'b0, 32'h0BAD_CAFE, "R4 hold high");
      drive(1'b0, CLRW ^ 32'h1, "R4 near-miss clear");
      drive(1'b0, CLRW, "R3 clear");
      drive(1'b0, SETW ^ 32'h8000_0000, "R4 near-miss set");
      drive(1'b0, 32'hFFFF_FFFF, "R4 hold low");
      drive(1'b0, SETW, "R6 prior set");
      drive(1'b0, CLRW, "R6 first clear");
      drive(1'b0, CLRW, "R6 second clear");
      drive(1'b0, SETW, "R6 set after clears");
      drive(1'b0, 32'h0, "R6 hold after set");
      drive(1'b1, SETW, "R7 reset over set");
      drive(1'b0, 32'h5555_AAAA, "R7 idle after reset");
      for (int i = 0; i < 6; i++) begin
         drive(1'b0, (i % 2 == 0) ? SETW : CLRW, "R8 alternate");
      end
      drive(1'b0, EQW, "R5 equal patterns set wins");
      drive(1'b0, 32'h0, "R5 hold");
      drive(1'b1, 32'h0, "R1 reset again");
      drive(1'b0, EQW, "R5 set from reset");
      for (int i = 0; i < 8; i++) begin
         drive(1'b0, 32'h1 << (i * 4), "R4 walking word");
      end
      drive(1'b0, 32'h0, "R4 final");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule